// File: doc/BRIEF.md
# Flash Code-Fetch Prefetch Controller

This block sits between a processor read port and an embedded flash array that returns 32-bit words. It answers byte, halfword and word reads. It stretches each flash access by a programmable number of wait cycles, and it keeps two 32-bit line buffers. These buffers hide most of that latency when the processor runs a sequential stream of 16-bit instructions.

When a 16-bit instruction fetch reads the upper halfword of a buffered word, the block answers it from the buffer. In that same cycle it launches the flash read of the following word, so the next fetch finds its word already arriving or already stored. Data reads may hit the buffers, but they never launch a look-ahead read, and a data read that misses leaves the buffer contents alone. The flash word address is the request address folded onto the array size, so the array repeats across a larger memory window.

Top module: `fcf_prefetch_ctrl`

## Requirements
- R1: The wait-state setting `cfg_ws` takes the values 0 to 3. A read whose word is neither buffered nor in flight raises `req_ready` exactly `cfg_ws` cycles after the cycle in which it is first presented.
- R2: With `cfg_ws` = 0, every read is answered in the cycle in which it is presented.
- R3: Two distinct flash words can be held at once. After both are loaded, reading either of them again is answered with no wait cycle.
- R4: A 16-bit instruction fetch (`req_fetch` = 1, `req_size` = 1, address bit 1 set) answered from a buffer drives `fl_strobe` with `fl_addr` equal to the next word address, in that same cycle.
- R5: In a sequential halfword fetch stream, the wait for each new word is shortened by the cycles already spent on its look-ahead read. With one wait state, only the first word of the stream stalls.
- R6: Data reads (`req_fetch` = 0) never start a read of the next word.
- R7: `req_size` 0 selects a byte, 1 a halfword, and 2 or 3 the whole word. The byte or halfword is picked by the low address bits and returned zero-extended in the low bits of `req_rdata`.
- R8: `fl_addr` equals byte-address bits [FLASH_AW+1:2], so aliased addresses read, and hit on, the same flash word.
- R9: A fetch miss while a look-ahead read is in flight abandons that read and pays the full wait. The abandoned word is not buffered.
- R10: A data read that hits a buffer is answered at once. A data read that misses waits for any look-ahead read to land and then reads flash without changing the buffers, so the look-ahead word still hits afterwards.
- R11: Reset, or any change of `cfg_ws`, empties both buffers. The next read of a formerly buffered word pays the full wait.
- R12: `req_ready` stays low, and `fl_strobe` stays low, while no read is presented after reset. Whenever `req_ready` is high, `req_rdata` carries the addressed flash data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ws | input | 2 | Flash wait-state count |
| req_valid | input | 1 | Read presented; held until accepted |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_fetch | input | 1 | 1 for instruction fetch, 0 for data |
| req_ready | output | 1 | Read answered this cycle |
| req_rdata | output | 32 | Read data, zero-extended |
| fl_addr | output | FLASH_AW | Flash word address |
| fl_strobe | output | 1 | Flash access active |
| fl_rdata | input | 32 | Flash word, valid after configured latency |

## Verification
The bench builds the block with a 12-bit address and a 64-word flash. This keeps the aliasing window small, so a request at 0x504 folds onto word 1, and the bench can record every flash word touched in a 64-bit map. The flash model returns a poison word until an address has been held for the configured number of cycles. The bench switches the wait-state input among 0, 1, 2 and 3. This makes single-cycle reads, the stall-free stream at one wait state, partly hidden look-ahead at three wait states, abandoned look-ahead and flush-on-change all observable.

// File: rtl/fcf_pkg.sv
package fcf_pkg;

  // request size encoding seen on req_size
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } xfer_size_e;

  localparam int WORD_W   = 32;
  localparam int CNT_W    = 2;

endpackage

// File: rtl/fcf_line_buf.sv
module fcf_line_buf #(
  parameter int TAG_W  = 15,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [TAG_W-1:0]  look_tag_i,
  output logic              hit_o,
  output logic              hit_idx_o,
  output logic [DATA_W-1:0] hit_data_o,
  input  logic [TAG_W-1:0]  probe_tag_i,
  output logic              probe_hit_o,
  input  logic              touch_i,
  input  logic              fill_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i
);

  localparam int NENT = 2;

  logic [NENT-1:0]   vld_q, vld_n;
  logic [TAG_W-1:0]  tag_q [NENT];
  logic [TAG_W-1:0]  tag_n [NENT];
  logic [DATA_W-1:0] dat_q [NENT];
  logic [DATA_W-1:0] dat_n [NENT];
  logic              lru_q, lru_n;
  logic              victim;
  logic [NENT-1:0]   look_match, probe_match;

  for (genvar g = 0; g < NENT; g++) begin : g_cmp
    assign look_match[g]  = vld_q[g] && (tag_q[g] == look_tag_i);
    assign probe_match[g] = vld_q[g] && (tag_q[g] == probe_tag_i);
  end

  assign hit_o       = |look_match;
  assign hit_idx_o   = look_match[1];
  assign hit_data_o  = look_match[1] ? dat_q[1] : dat_q[0];
  assign probe_hit_o = |probe_match;

  // a look-ahead fill must not evict the word being read this cycle
  assign victim = (touch_i && hit_o) ? ~hit_idx_o : lru_q;

  always_comb begin
    vld_n = vld_q;
    tag_n = tag_q;
    dat_n = dat_q;
    lru_n = lru_q;
    if (flush_i) begin
      vld_n = '0;
    end else begin
      if (touch_i && hit_o) lru_n = ~hit_idx_o;
      if (fill_i) begin
        vld_n[victim] = 1'b1;
        tag_n[victim] = fill_tag_i;
        dat_n[victim] = fill_data_i;
        lru_n         = ~victim;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lru_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
      lru_q <= lru_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_i) begin
      tag_q <= tag_n;
      dat_q <= dat_n;
    end
  end

  // R11
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !hit_o && !probe_hit_o);

  // R3
  fill_then_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_i && !flush_i && look_tag_i == fill_tag_i) |=> $stable(look_tag_i) |-> hit_o);

endmodule

// File: rtl/fcf_flash_seq.sv
module fcf_flash_seq
  import fcf_pkg::*;
#(
  parameter int TAG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] ws_i,
  input  logic             flush_i,
  input  logic             start_i,
  input  logic [TAG_W-1:0] start_tag_i,
  input  logic             start_pref_i,
  input  logic             start_fill_i,
  output logic             busy_o,
  output logic             pref_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             act_o,
  output logic [TAG_W-1:0] act_tag_o,
  output logic             act_done_o,
  output logic             act_fill_o
);

  logic             busy_q, busy_n;
  logic             pref_q, pref_n;
  logic             fill_q, fill_n;
  logic [TAG_W-1:0] tag_q, tag_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] act_cnt;
  logic             act_pref;

  // the access running this cycle: a new one replaces any in flight
  always_comb begin
    act_o      = 1'b0;
    act_tag_o  = tag_q;
    act_cnt    = cnt_q;
    act_pref   = pref_q;
    act_fill_o = fill_q;
    if (start_i) begin
      act_o      = 1'b1;
      act_tag_o  = start_tag_i;
      act_cnt    = '0;
      act_pref   = start_pref_i;
      act_fill_o = start_fill_i;
    end else if (busy_q && !flush_i) begin
      act_o      = 1'b1;
    end
  end

  assign act_done_o = act_o && (act_cnt == ws_i);

  always_comb begin
    busy_n = 1'b0;
    pref_n = pref_q;
    fill_n = fill_q;
    tag_n  = tag_q;
    cnt_n  = '0;
    if (!flush_i && act_o && !act_done_o) begin
      busy_n = 1'b1;
      pref_n = act_pref;
      fill_n = act_fill_o;
      tag_n  = act_tag_o;
      cnt_n  = act_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (busy_n) begin
      pref_q <= pref_n;
      fill_q <= fill_n;
      tag_q  <= tag_n;
    end
  end

  assign busy_o = busy_q;
  assign pref_o = pref_q;
  assign tag_o  = tag_q;
  assign cnt_o  = cnt_q;

  // R1
  wait_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (cnt_q != '0) && (cnt_q <= ws_i));

endmodule

// File: rtl/fcf_lane_sel.sv
module fcf_lane_sel
  import fcf_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic [1:0]        lane_i,
  input  xfer_size_e        size_i,
  output logic [WORD_W-1:0] data_o
);

  logic [WORD_W-1:0] shifted;

  assign shifted = word_i >> {lane_i, 3'b000};

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(WORD_W-8){1'b0}}, shifted[7:0]};
      SZ_HALF: data_o = {{(WORD_W-16){1'b0}}, shifted[15:0]};
      default: data_o = word_i;
    endcase
  end

endmodule

// File: rtl/fcf_prefetch_ctrl.sv
module fcf_prefetch_ctrl
  import fcf_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int FLASH_AW = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_ws,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_fetch,
  output logic                req_ready,
  output logic [31:0]         req_rdata,
  output logic [FLASH_AW-1:0] fl_addr,
  output logic                fl_strobe,
  input  logic [31:0]         fl_rdata
);

  localparam int TAG_W = FLASH_AW;

  logic [CNT_W-1:0] ws_q;
  logic             flush;
  logic [TAG_W-1:0] req_tag, next_tag;
  logic             half_hi_fetch;
  logic             unused_hi_addr;

  logic             bf_hit, bf_hit_idx, bf_probe_hit, bf_touch, bf_fill;
  logic [WORD_W-1:0] bf_data;

  logic             sq_busy, sq_pref, sq_act, sq_done, sq_fill;
  logic [TAG_W-1:0] sq_tag, sq_act_tag, sq_start_tag;
  logic [CNT_W-1:0] sq_cnt;
  logic             pend_hit, start_dem, start_pref, sq_start;
  logic             served_flash;
  logic [WORD_W-1:0] sel_word;

  assign unused_hi_addr = ^req_addr[ADDR_W-1:FLASH_AW+2];

  assign flush         = (cfg_ws != ws_q);
  assign req_tag       = req_addr[FLASH_AW+1:2];
  assign next_tag      = req_tag + TAG_W'(1);
  assign half_hi_fetch = req_fetch && (xfer_size_e'(req_size) == SZ_HALF) && req_addr[1];

  // word already travelling through the flash sequencer
  assign pend_hit  = sq_busy && (sq_tag == req_tag);

  // fetch misses abandon a look-ahead; data misses queue behind it
  assign start_dem = req_valid && !flush && !bf_hit && !pend_hit &&
                     (!sq_busy || (sq_pref && req_fetch));

  assign start_pref = req_valid && !flush && bf_hit && half_hi_fetch &&
                      !sq_busy && !bf_probe_hit;

  assign sq_start     = start_dem || start_pref;
  assign sq_start_tag = start_dem ? req_tag : next_tag;

  fcf_flash_seq #(.TAG_W(TAG_W)) seq_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ws_i         (ws_q),
    .flush_i      (flush),
    .start_i      (sq_start),
    .start_tag_i  (sq_start_tag),
    .start_pref_i (!start_dem),
    .start_fill_i (req_fetch),
    .busy_o       (sq_busy),
    .pref_o       (sq_pref),
    .tag_o        (sq_tag),
    .cnt_o        (sq_cnt),
    .act_o        (sq_act),
    .act_tag_o    (sq_act_tag),
    .act_done_o   (sq_done),
    .act_fill_o   (sq_fill)
  );

  assign bf_touch = req_valid && bf_hit && !flush;
  assign bf_fill  = sq_done && sq_fill && !flush;

  fcf_line_buf #(.TAG_W(TAG_W), .DATA_W(WORD_W)) buf_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush_i     (flush),
    .look_tag_i  (req_tag),
    .hit_o       (bf_hit),
    .hit_idx_o   (bf_hit_idx),
    .hit_data_o  (bf_data),
    .probe_tag_i (next_tag),
    .probe_hit_o (bf_probe_hit),
    .touch_i     (bf_touch),
    .fill_i      (bf_fill),
    .fill_tag_i  (sq_act_tag),
    .fill_data_i (fl_rdata)
  );

  assign served_flash = sq_done && (sq_act_tag == req_tag);
  assign req_ready    = !flush && (bf_hit || served_flash);
  assign sel_word     = bf_hit ? bf_data : fl_rdata;

  fcf_lane_sel lane_i (
    .word_i (sel_word),
    .lane_i (req_addr[1:0]),
    .size_i (xfer_size_e'(req_size)),
    .data_o (req_rdata)
  );

  assign fl_addr   = sq_act_tag;
  assign fl_strobe = sq_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ws_q <= '0;
    else        ws_q <= cfg_ws;
  end

  // R2
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ws_q == 2'd0 && cfg_ws == 2'd0) |-> req_ready);

  // R6
  fetch_only_lookahead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_busy && sq_pref && sq_cnt == 2'd1) |-> $past(req_valid && req_fetch));

  // R8
  folded_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !bf_hit) |-> (fl_strobe && fl_addr == req_addr[FLASH_AW+1:2]));

  // R4
  lookahead_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && bf_hit && half_hi_fetch && !sq_busy && !bf_probe_hit)
      |-> (fl_strobe && fl_addr == req_addr[FLASH_AW+1:2] + TAG_W'(1)));

endmodule

// File: tb/fcf_prefetch_ctrl_tb_top.sv
module fcf_prefetch_ctrl_tb_top;

  localparam int AW  = 12;
  localparam int FAW = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [1:0]     cfg_ws;
  logic           req_valid;
  logic [AW-1:0]  req_addr;
  logic [1:0]     req_size;
  logic           req_fetch;
  logic           req_ready;
  logic [31:0]    req_rdata;
  logic [FAW-1:0] fl_addr;
  logic           fl_strobe;
  logic [31:0]    fl_rdata;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fcf_prefetch_ctrl #(.ADDR_W(AW), .FLASH_AW(FAW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ws(cfg_ws),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_fetch(req_fetch), .req_ready(req_ready), .req_rdata(req_rdata),
    .fl_addr(fl_addr), .fl_strobe(fl_strobe), .fl_rdata(fl_rdata)
  );

  function automatic logic [31:0] word_val(input int w);
    return 32'h9E37_79B9 * (w + 1);
  endfunction

  function automatic int widx(input logic [AW-1:0] a);
    return int'((a >> 2) & 12'h3F);
  endfunction

  function automatic logic [31:0] half_val(input logic [AW-1:0] a);
    return (word_val(widx(a)) >> (a[1] ? 16 : 0)) & 32'h0000_FFFF;
  endfunction

  // flash array model: poison until address held for cfg_ws extra cycles
  logic [FAW-1:0] m_addr_q;
  logic           m_prev_q;
  int             m_age_q;
  logic [63:0]    seen;
  logic           seen_clr = 1'b0;

  always @(posedge clk) begin
    if (fl_strobe) begin
      m_age_q  <= (m_prev_q && fl_addr == m_addr_q) ? m_age_q + 1 : 1;
      m_addr_q <= fl_addr;
      m_prev_q <= 1'b1;
    end else begin
      m_age_q  <= 0;
      m_prev_q <= 1'b0;
    end
    if (seen_clr) seen <= '0;
    else if (fl_strobe) seen[fl_addr] <= 1'b1;
  end

  always_comb begin
    automatic int held = (m_prev_q && fl_addr == m_addr_q) ? m_age_q + 1 : 1;
    fl_rdata = (held >= int'(cfg_ws) + 1) ? word_val(int'(fl_addr)) : 32'hBAD0_0BAD;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [AW-1:0] a, input logic [1:0] sz, input logic f,
                      output logic [31:0] d, output int w,
                      output logic s, output logic [FAW-1:0] fa);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_fetch = f; w = 0;
    #1;
    while (!req_ready && w < 40) begin @(posedge clk); #1; w++; end
    d = req_rdata; s = fl_strobe; fa = fl_addr;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic set_ws(input logic [1:0] v);
    cfg_ws = v;
    repeat (2) @(posedge clk);
    #1;
  endtask

  // fetch/data read with data and wait check
  task automatic rd(input logic [AW-1:0] a, input logic [1:0] sz, input logic f,
                    input int exp_w, input string rq);
    logic [31:0] d; int w; logic s; logic [FAW-1:0] fa; logic [31:0] e;
    xfer(a, sz, f, d, w, s, fa);
    e = (sz == 2'd1) ? half_val(a) : (sz == 2'd0) ?
        ((word_val(widx(a)) >> (8 * a[1:0])) & 32'hFF) : word_val(widx(a));
    chk(w == exp_w, rq, $sformatf("wait @%0h", a), w, exp_w);
    chk(d == e, "R12", $sformatf("data @%0h", a), d, e);
  endtask

  task automatic t_reset;
    #1;
    chk(req_ready == 1'b0, "R12", "ready in reset", req_ready, 0);
    chk(fl_strobe == 1'b0, "R12", "strobe in reset", fl_strobe, 0);
  endtask

  task automatic t_ws0;
    rd(12'h100, 2'd1, 1'b1, 0, "R2");
    rd(12'h102, 2'd1, 1'b1, 0, "R2");
    rd(12'h104, 2'd1, 1'b1, 0, "R2");
    rd(12'h1F8, 2'd2, 1'b0, 0, "R2");
  endtask

  task automatic t_sizes;
    rd(12'h121, 2'd0, 1'b0, 0, "R7");
    rd(12'h123, 2'd0, 1'b0, 0, "R7");
    rd(12'h122, 2'd1, 1'b0, 0, "R7");
    rd(12'h120, 2'd3, 1'b0, 0, "R7");
  endtask

  task automatic t_seq_ws1;
    logic [31:0] d; int w; logic s; logic [FAW-1:0] fa;
    set_ws(2'd1);
    rd(12'h040, 2'd1, 1'b1, 1, "R1");
    xfer(12'h042, 2'd1, 1'b1, d, w, s, fa);
    chk(s && fa == 6'h11, "R4", "lookahead strobe/addr", {26'd0, fa}, 32'h11);
    chk(w == 0, "R5", "hi half wait", w, 0);
    rd(12'h044, 2'd1, 1'b1, 0, "R5");
    rd(12'h046, 2'd1, 1'b1, 0, "R5");
    rd(12'h048, 2'd1, 1'b1, 0, "R5");
  endtask

  task automatic t_two_buf;
    rd(12'h060, 2'd2, 1'b1, 1, "R1");
    rd(12'h070, 2'd2, 1'b1, 1, "R1");
    rd(12'h060, 2'd2, 1'b1, 0, "R3");
    rd(12'h070, 2'd2, 1'b1, 0, "R3");
  endtask

  task automatic t_data;
    logic [31:0] d; int w; logic s; logic [FAW-1:0] fa;
    seen_clr = 1'b1; @(posedge clk); #1; seen_clr = 1'b0;
    rd(12'h0C0, 2'd1, 1'b1, 1, "R1");
    xfer(12'h0C2, 2'd1, 1'b0, d, w, s, fa);
    chk(w == 0, "R10", "data hit wait", w, 0);
    chk(s == 1'b0, "R6", "no strobe on data hi half", s, 0);
    rd(12'h0D0, 2'd2, 1'b0, 1, "R10");
    chk(seen[6'h31] == 1'b0, "R6", "next word never read", seen[6'h31], 0);
    rd(12'h0C2, 2'd1, 1'b1, 0, "R10");
  endtask

  task automatic t_wrap;
    logic [31:0] d; int w; logic s; logic [FAW-1:0] fa;
    xfer(12'h504, 2'd1, 1'b1, d, w, s, fa);
    chk(fa == 6'h01, "R8", "folded address", {26'd0, fa}, 1);
    chk(d == half_val(12'h504), "R8", "folded data", d, half_val(12'h504));
    chk(w == 1, "R8", "alias miss wait", w, 1);
    rd(12'h004, 2'd2, 1'b0, 0, "R8");
  endtask

  task automatic t_ws3;
    logic [31:0] d; int w; logic s; logic [FAW-1:0] fa;
    set_ws(2'd3);
    rd(12'h080, 2'd1, 1'b1, 3, "R1");
    xfer(12'h082, 2'd1, 1'b1, d, w, s, fa);
    chk(s && fa == 6'h21, "R4", "lookahead at ws3", {26'd0, fa}, 32'h21);
    rd(12'h084, 2'd1, 1'b1, 2, "R5");
  endtask

  task automatic t_abort;
    rd(12'h010, 2'd1, 1'b1, 3, "R1");
    rd(12'h012, 2'd1, 1'b1, 0, "R9");
    rd(12'h040, 2'd1, 1'b1, 3, "R9");
    rd(12'h014, 2'd1, 1'b1, 3, "R9");
  endtask

  task automatic t_data_wait;
    rd(12'h030, 2'd1, 1'b1, 3, "R1");
    rd(12'h032, 2'd1, 1'b1, 0, "R4");
    rd(12'h090, 2'd2, 1'b0, 6, "R10");
    rd(12'h034, 2'd1, 1'b1, 0, "R10");
  endtask

  task automatic t_flush;
    set_ws(2'd1);
    rd(12'h020, 2'd2, 1'b1, 1, "R11");
    rd(12'h020, 2'd2, 1'b1, 0, "R11");
    set_ws(2'd2);
    rd(12'h020, 2'd2, 1'b1, 2, "R11");
    rd(12'h020, 2'd2, 1'b1, 0, "R11");
    rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    rd(12'h020, 2'd2, 1'b1, 2, "R11");
  endtask

  initial begin
    rst_n = 1'b0; cfg_ws = 2'd0; req_valid = 1'b0;
    req_addr = '0; req_size = 2'd0; req_fetch = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(posedge clk); #1; rst_n = 1'b1;
    @(posedge clk); #1;
    t_ws0();
    t_sizes();
    t_seq_ws1();
    t_two_buf();
    t_data();
    t_wrap();
    t_ws3();
    t_abort();
    t_data_wait();
    t_flush();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R12 watchdog expired: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule